// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This unit rearranges bytes. It takes two 64-bit operands and builds a 64-bit result in which every byte is drawn from any of the sixteen operand bytes. The choice for each output byte comes from a 32-bit selector word. That word lives in the upper half of a 64-bit status register.

Two operations share one issue port. The mask-set operation adds its two operands and returns the full sum. It also stores the low 32 bits of that sum in the selector field, and the lower half of the status register is left alone. The shuffle operation then permutes a fresh pair of operands using the stored selector.

Results appear one cycle after issue. A shuffle issued back to back with a mask-set uses the new selector. A separate write port can load the whole status register, and the register is always visible on a read-back output.

Top module: `byte_shuffle_unit`

## Requirements
- R1: A mask-set operation (opSel = 0) returns srcA + srcB as a full 64-bit sum. The sum wraps modulo 2^64.
- R2: A mask-set writes sum bits 31:0 into status bits 63:32. Status bits 31:0 keep their value unless the write port loads them in the same cycle.
- R3: In a shuffle (opSel = 1), output byte i, with byte 0 the least significant, is steered by selector bits 4i+3:4i, taken from status bits 32+4i+3:32+4i.
- R4: A selector value v from 0 to 7 picks byte v of srcA. A value v from 8 to 15 picks byte v-8 of srcB. Byte 0 is the least significant byte of each operand.
- R5: Each output byte is chosen independently, so bytes may be reordered and the same source byte may appear several times.
- R6: An operation accepted on a rising edge while opValid is high shows its result on resData, with resValid high, for the following cycle. When no operation is accepted, resValid is low and resData holds its last value.
- R7: A shuffle issued in the cycle right after a mask-set uses the selector written by that mask-set.
- R8: Synchronous reset clears the status register and resValid. A shuffle after reset therefore returns byte 0 of srcA in all eight positions.
- R9: When statWrEn is high, all 64 status bits load from statWrData on the edge. A mask-set on the same edge wins for bits 63:32.
- R10: statusOut shows the status register contents at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Issue an operation this cycle |
| opSel | input | 1 | 0 selects mask-set, 1 selects shuffle |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| statWrEn | input | 1 | Load the whole status register |
| statWrData | input | 64 | Value for the status load |
| resValid | output | 1 | Result is valid this cycle |
| resData | output | 64 | Operation result |
| statusOut | output | 64 | Status register read-back |

## Verification
The bench loads each of the sixteen selector values into each of the eight lanes with a mask-set, then shuffles on the very next cycle. This catches three kinds of fault:
- A unit with a stale selector path returns the result for the previous mask.
- A unit that mixes up the operand halves swaps srcA bytes for srcB bytes.
- A unit that reverses lanes puts the selected byte in the wrong position.

Mixed selectors test duplicated and reversed bytes, each against an arithmetic model. A carry across bit 63 tests the wrap of the sum. A preloaded lower status half exposes a mask-set that clobbers bits 31:0. A same-cycle write and mask-set show whether the wrong source wins the upper field. Reset is applied twice to show that the all-zero selector replicates byte 0.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic {
    OP_MASKSET = 1'b0,
    OP_SHUFFLE = 1'b1
  } bsu_op_e;

  typedef struct packed {
    logic maskSet;
    logic shuffle;
    logic statLoad;
    logic resLoad;
  } bsu_strobe_t;

endpackage

// File: rtl/bsu_lane_mux.sv
module bsu_lane_mux #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [SEL_W-1:0]  sel,
  output logic [LANE_W-1:0] laneOut
);
  localparam int POOL_W = 2 * DATA_W;

  logic [POOL_W-1:0] pool;

  // srcA fills the low byte indices, srcB the high ones
  assign pool    = {srcB, srcA};
  assign laneOut = pool[sel * LANE_W +: LANE_W];
endmodule

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic        opSel,
  input  logic        statWrEn,
  output bsu_strobe_t strobe,
  output logic        resValid
);
  bsu_op_e opKind;

  assign opKind = bsu_op_e'(opSel);

  always_comb begin
    strobe          = '0;
    strobe.resLoad  = opValid && !rst;
    strobe.maskSet  = opValid && !rst && (opKind == OP_MASKSET);
    strobe.shuffle  = opValid && !rst && (opKind == OP_SHUFFLE);
    strobe.statLoad = statWrEn && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else     resValid <= strobe.resLoad;
  end

  // R6: valid follows acceptance by exactly one cycle
  assert_valid_after_issue_R6: assert property (@(posedge clk) disable iff (rst)
    opValid |=> resValid);
  assert_idle_no_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> !resValid);
endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bsu_strobe_t       strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] statWrData,
  output logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] statusReg
);
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int SEL_W     = $clog2(2 * NUM_LANES);
  localparam int MASK_W    = NUM_LANES * SEL_W;
  localparam int LOW_W     = DATA_W - MASK_W;

  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] shufVal;
  logic [MASK_W-1:0] maskField;

  assign sumVal    = srcA + srcB;
  assign maskField = statusReg[DATA_W-1 -: MASK_W];

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    bsu_lane_mux #(
      .DATA_W(DATA_W),
      .LANE_W(LANE_W),
      .SEL_W (SEL_W)
    ) u_laneMux (
      .srcA   (srcA),
      .srcB   (srcB),
      .sel    (maskField[g*SEL_W +: SEL_W]),
      .laneOut(shufVal[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusReg <= '0;
    end else begin
      if (strobe.statLoad) statusReg <= statWrData;
      if (strobe.maskSet)  statusReg[DATA_W-1 -: MASK_W] <= sumVal[MASK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                resData <= '0;
    else if (strobe.resLoad) resData <= strobe.maskSet ? sumVal : shufVal;
  end

  assert_sum_returned_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe.resLoad && strobe.maskSet) |=> resData == ($past(srcA) + $past(srcB)));
  assert_mask_from_sum_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.maskSet |=> statusReg[DATA_W-1 -: MASK_W] ==
      ($past(srcA[MASK_W-1:0]) + $past(srcB[MASK_W-1:0])));
  assert_low_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.maskSet && !strobe.statLoad) |=> $stable(statusReg[LOW_W-1:0]));
  assert_write_low_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.statLoad |=> statusReg[LOW_W-1:0] == $past(statWrData[LOW_W-1:0]));
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe.resLoad |=> $stable(resData));
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic              opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              statWrEn,
  input  logic [DATA_W-1:0] statWrData,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] statusOut
);
  bsu_strobe_t strobe;

  bsu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opValid (opValid),
    .opSel   (opSel),
    .statWrEn(statWrEn),
    .strobe  (strobe),
    .resValid(resValid)
  );

  bsu_datapath #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .srcA      (srcA),
    .srcB      (srcB),
    .statWrData(statWrData),
    .resData   (resData),
    .statusReg (statusOut)
  );
endmodule

// File: tb/byte_shuffle_unit_bench.sv
`timescale 1ns/1ps
module byte_shuffle_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic        opSel = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        statWrEn = 1'b0;
  logic [63:0] statWrData = '0;
  logic        resValid;
  logic [63:0] resData;
  logic [63:0] statusOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  localparam logic [63:0] OPA = 64'h1716_1514_1312_1110;
  localparam logic [63:0] OPB = 64'h2726_2524_2322_2120;

  always #4 clk = ~clk;

  byte_shuffle_unit u_byte_shuffle_unit (
    .clk(clk), .rst(rst), .opValid(opValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .statWrEn(statWrEn), .statWrData(statWrData),
    .resValid(resValid), .resData(resData), .statusOut(statusOut)
  );

  function automatic logic [63:0] model(input logic [31:0] m, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int v = int'(m[4*i +: 4]);
      if (v < 8) r[8*i +: 8] = a[8*v +: 8];
      else       r[8*i +: 8] = b[8*(v-8) +: 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic sel, input logic [63:0] a, input logic [63:0] b);
    opValid = 1'b1; opSel = sel; srcA = a; srcB = b;
    tick();
  endtask

  task automatic idle();
    opValid = 1'b0;
    tick();
  endtask

  task automatic doReset();
    rst = 1'b1; opValid = 1'b0; statWrEn = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  initial begin
    logic [63:0] held;
    logic [31:0] m;
    doReset();
    chk("R8 status after reset", statusOut, 64'h0);
    chk("R8 valid after reset", {63'h0, resValid}, 64'h0);
    drive(1'b1, 64'h0807_0605_0403_0201, OPB);
    chk("R8 zero selector replicates byte0", resData, 64'h0101_0101_0101_0101);
    chk("R6 valid after shuffle", {63'h0, resValid}, 64'h1);

    // R1 wrap of the sum; R2 upper field
    drive(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);
    chk("R1 wrapped sum", resData, 64'h1);
    chk("R2 upper field from sum", statusOut, 64'h0000_0001_0000_0000);
    idle();
    chk("R6 valid low when idle", {63'h0, resValid}, 64'h0);
    chk("R6 result held when idle", resData, 64'h1);

    // R9 full load via write port; R10 read-back
    statWrEn = 1'b1; statWrData = 64'hAAAA_BBBB_1234_5678;
    tick();
    statWrEn = 1'b0;
    chk("R9 R10 full status load", statusOut, 64'hAAAA_BBBB_1234_5678);
    drive(1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0007);
    chk("R1 full 64-bit sum", resData, 64'h0000_0001_0000_0007);
    chk("R2 low half kept", statusOut, 64'h0000_0007_1234_5678);

    // R9 priority: same-cycle write and mask-set
    statWrEn = 1'b1; statWrData = 64'h1111_2222_3333_4444;
    drive(1'b0, 64'h5, 64'h0);
    statWrEn = 1'b0;
    chk("R9 mask-set wins upper half", statusOut, 64'h0000_0005_3333_4444);
    idle();

    // R3 R4 R7 sweep: every selector value in every lane, shuffle back to back
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 16; v++) begin
        m = 32'(v) << (4 * p);
        drive(1'b0, {32'h0, m}, 64'h0);
        chk("R1 sum for selector load", resData, {32'h0, m});
        drive(1'b1, OPA, OPB);
        chk("R3 R4 R7 lane sweep", resData, model(m, OPA, OPB));
      end
    end
    idle();

    // R5 reorder and duplication patterns
    drive(1'b0, 64'h0123_4567, 64'h0);
    drive(1'b1, OPA, OPB);
    chk("R5 byte reversal", resData, 64'h1011_1213_1415_1617);
    drive(1'b0, 64'hFFFF_FFFF, 64'h0);
    drive(1'b1, OPA, OPB);
    chk("R5 all lanes srcB byte7", resData, 64'h2727_2727_2727_2727);
    for (int k = 1; k <= 24; k++) begin
      m = 32'(k) * 32'h9E37_79B9;
      drive(1'b0, {32'h0, m - 32'h100}, 64'h100);
      drive(1'b1, OPA ^ (64'(k) << 5), OPB + 64'(k));
      chk("R5 mixed selectors", resData, model(m, OPA ^ (64'(k) << 5), OPB + 64'(k)));
    end
    idle();
    held = resData;
    idle();
    chk("R6 held over idle cycles", resData, held);

    // R8 reset again mid-run
    doReset();
    chk("R8 status cleared again", statusOut, 64'h0);
    drive(1'b1, 64'hDEAD_BEEF_CAFE_F00D, OPB);
    chk("R8 replicate byte0 after reset", resData, 64'h0D0D_0D0D_0D0D_0D0D);
    idle();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule